// File: doc/BRIEF.md
# Pixel to Bus Cycle Packer

This block takes a stream of pixels that are 12, 16, 18 or 24 bits wide and cuts each pixel into words for a parallel display bus that carries 8, 9, 12 or 16 data lines. The number of bus words per pixel follows from the pixel width and the bus width. A pixel can go out as one, two or three whole bus words. In the paired format, two pixels share three bus words. Pixel and bus width combinations that fit neither pattern are refused.

A frame starts with a one-cycle `start` pulse. With it come the pixel count for the frame (width times height) and the two configuration codes. The block takes the configuration at that pulse and raises `busy`. It then pulls exactly that many pixels through a valid/ready input and sends the resulting words through a valid/ready output. A downstream bus timer turns these words into strobes. After the final word has been taken, `frame_done` pulses and `busy` drops.

Top module: `pixel_bus_packer`

## Requirements
- R1: `cfg_pix_type` selects the pixel width (0 = 12, 1 = 16, 2 = 18, 3 = 24 bits). `cfg_bus_mode` selects the line count (0 = 8, 1 = 9, 2 = 12, 3 = 16 lines). The format is derived from bits divided by lines: a quotient of 1, 2 or 3 gives that many words per pixel, and twice the bits over the lines equal to 3 gives the paired format. A `start` with any other combination is ignored: `busy` stays low, no word is sent and no `frame_done` occurs.
- R2: In the whole-word formats with K words per pixel, a pixel of P bits sends word k (k = 0..K-1) equal to bits [P-1-k*L : P-L*(k+1)], the most significant part first. Each word sits in the low L bits of `bus_data`, with zeros above. Pixel input bits at and above P are ignored.
- R3: In the paired format, pixels A then B form the value {A, B} of 3L bits, and this value is sent as three L-bit words, most significant first. The first word is therefore the top L bits of A. The second word holds the low L/2 bits of A in its upper half and the top L/2 bits of B in its lower half. The third word is the low L bits of B.
- R4: In the paired format, an odd last pixel A sends only two words: the top L bits of A, then the low L/2 bits of A in the upper half with zeros in the lower half.
- R5: A `start` with a supported format and a nonzero count N raises `busy` in the next cycle. Exactly N pixels are then accepted, and `pix_ready` is high only while `busy` is high.
- R6: `frame_done` is high for exactly one cycle, in the cycle after the handshake of the last word. `busy` is low from that same cycle.
- R7: A `start` with a count of zero sends no words, keeps `busy` low, and pulses `frame_done` in the cycle after the `start`.
- R8: Once `bus_valid` is high, it and `bus_data` stay unchanged until `bus_ready` is seen high.
- R9: While `busy` is high, changes on `start`, `frame_pixels`, `cfg_pix_type` and `cfg_bus_mode` have no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pix_type | input | 2 | Pixel width code, sampled at start |
| cfg_bus_mode | input | 2 | Bus line count code, sampled at start |
| frame_pixels | input | CNT_W | Pixels in the frame, sampled at start |
| start | input | 1 | One-cycle frame start request |
| pix_valid | input | 1 | Input pixel valid |
| pix_data | input | PIX_W | Input pixel, right-aligned |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| bus_valid | output | 1 | Output word valid |
| bus_data | output | BUS_W | Output word, right-aligned to the line count |
| bus_ready | input | 1 | Bus timer takes the word |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at frame end |

## Verification
The assertions assume that `bus_ready` comes only from a consumer and does not depend on `bus_valid` within the same cycle. They also assume that `start` arrives while the block is idle or is meant to be dropped. The bench drives every input at the falling edge and takes both handshakes from values that are stable across the next rising edge, so the ready and valid patterns never race the design. The sweep covers all sixteen width pairs, odd and even pixel counts and three throttling patterns, and it scrambles the configuration inputs and the pixel bits above the pixel width while a frame runs.

// File: rtl/pk_pkg.sv
package pk_pkg;

  typedef enum logic [1:0] {
    FMT_ONE   = 2'd0,
    FMT_TWO   = 2'd1,
    FMT_THREE = 2'd2,
    FMT_PAIR  = 2'd3
  } fmt_e;

  function automatic int type_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 12;
      2'd1:    return 16;
      2'd2:    return 18;
      default: return 24;
    endcase
  endfunction

  function automatic int mode_lines(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 9;
      2'd2:    return 12;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/pk_fmt_decode.sv
module pk_fmt_decode
  import pk_pkg::*;
(
  input  logic [1:0] pix_type,
  input  logic [1:0] bus_mode,
  output logic [4:0] pbits,
  output logic [4:0] lines,
  output fmt_e       fmt,
  output logic [1:0] last_phase,
  output logic       ok
);

  int pb;
  int ln;

  always_comb begin
    pb         = type_bits(pix_type);
    ln         = mode_lines(bus_mode);
    pbits      = 5'(pb);
    lines      = 5'(ln);
    ok         = 1'b1;
    fmt        = FMT_ONE;
    last_phase = 2'd0;
    if (pb == ln) begin
      fmt        = FMT_ONE;
      last_phase = 2'd0;
    end else if (pb == 2 * ln) begin
      fmt        = FMT_TWO;
      last_phase = 2'd1;
    end else if (pb == 3 * ln) begin
      fmt        = FMT_THREE;
      last_phase = 2'd2;
    end else if (2 * pb == 3 * ln) begin
      fmt        = FMT_PAIR;
      last_phase = 2'd2;
    end else begin
      ok = 1'b0;
    end
  end

endmodule

// File: rtl/pk_frame_counter.sv
module pk_frame_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (load) begin
      rem <= load_val;
    end else if (dec) begin
      rem <= rem - CNT_W'(1);
    end
  end

  assign zero = (rem == '0);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);

endmodule

// File: rtl/pk_word_slicer.sv
module pk_word_slicer #(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  input  logic [4:0]       pbits,
  input  logic [4:0]       lines,
  input  logic [1:0]       phase,
  output logic [BUS_W-1:0] word
);

  localparam int VW = 2 * PIX_W;

  logic [VW-1:0] joined;
  logic [VW-1:0] shifted;
  logic [VW-1:0] lane_mask;
  logic [VW-1:0] lane;
  int            shamt;

  // The pixel pair {a, b} is treated as one wide value and cut MSB first;
  // in whole-word formats b is zero and lies below every cut.
  always_comb begin
    shamt = 2 * int'(pbits) - int'(lines) * (int'(phase) + 1);
    if (shamt < 0) shamt = 0;
    joined    = (VW'(pix_a) << pbits) | VW'(pix_b);
    shifted   = joined >> shamt;
    lane_mask = (VW'(1) << lines) - VW'(1);
    lane      = shifted & lane_mask;
    word      = lane[BUS_W-1:0];
  end

endmodule

// File: rtl/pixel_bus_packer.sv
module pixel_bus_packer
  import pk_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_pix_type,
  input  logic [1:0]       cfg_bus_mode,
  input  logic [CNT_W-1:0] frame_pixels,
  input  logic             start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             bus_valid,
  output logic [BUS_W-1:0] bus_data,
  input  logic             bus_ready,
  output logic             busy,
  output logic             frame_done
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_A,
    ST_GET_B,
    ST_EMIT,
    ST_DRAIN
  } st_e;

  st_e              state;
  logic [1:0]       run_type;
  logic [1:0]       run_mode;
  logic [PIX_W-1:0] hold_a;
  logic [PIX_W-1:0] hold_b;
  logic [1:0]       phase;
  logic             tail;

  logic [4:0]       live_pbits, live_lines, run_pbits, run_lines;
  fmt_e             live_fmt, run_fmt;
  logic [1:0]       live_last, run_last;
  logic             live_ok, run_ok;

  logic             cnt_zero;
  logic             take_pix;
  logic             load_cnt;
  logic             slot_free;
  logic [1:0]       end_phase;
  logic [BUS_W-1:0] next_word;
  logic [PIX_W:0]   pmask_w;
  logic [PIX_W-1:0] pix_masked;

  // Live decode judges the start request; run decode drives the frame.
  pk_fmt_decode u_dec_live (
    .pix_type   (cfg_pix_type),
    .bus_mode   (cfg_bus_mode),
    .pbits      (live_pbits),
    .lines      (live_lines),
    .fmt        (live_fmt),
    .last_phase (live_last),
    .ok         (live_ok)
  );

  pk_fmt_decode u_dec_run (
    .pix_type   (run_type),
    .bus_mode   (run_mode),
    .pbits      (run_pbits),
    .lines      (run_lines),
    .fmt        (run_fmt),
    .last_phase (run_last),
    .ok         (run_ok)
  );

  pk_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load_cnt),
    .load_val (frame_pixels),
    .dec      (take_pix),
    .zero     (cnt_zero)
  );

  pk_word_slicer #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_slice (
    .pix_a (hold_a),
    .pix_b (hold_b),
    .pbits (run_pbits),
    .lines (run_lines),
    .phase (phase),
    .word  (next_word)
  );

  assign pix_ready  = (state == ST_GET_A) || (state == ST_GET_B);
  assign take_pix   = pix_ready && pix_valid;
  assign load_cnt   = (state == ST_IDLE) && start && live_ok;
  assign slot_free  = !bus_valid || bus_ready;
  assign end_phase  = (run_fmt == FMT_PAIR && tail) ? 2'd1 : run_last;
  assign pmask_w    = ((PIX_W+1)'(1) << run_pbits) - (PIX_W+1)'(1);
  assign pix_masked = pix_data & pmask_w[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      run_type   <= '0;
      run_mode   <= '0;
      hold_a     <= '0;
      hold_b     <= '0;
      phase      <= '0;
      tail       <= 1'b0;
      bus_valid  <= 1'b0;
      bus_data   <= '0;
      busy       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (bus_valid && bus_ready) bus_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && live_ok) begin
            run_type <= cfg_pix_type;
            run_mode <= cfg_bus_mode;
            if (frame_pixels == '0) begin
              frame_done <= 1'b1;
            end else begin
              busy  <= 1'b1;
              state <= ST_GET_A;
            end
          end
        end
        ST_GET_A: begin
          if (pix_valid) begin
            hold_a <= pix_masked;
            hold_b <= '0;
            phase  <= 2'd0;
            tail   <= 1'b0;
            state  <= ST_EMIT;
          end
        end
        ST_GET_B: begin
          if (pix_valid) begin
            hold_b <= pix_masked;
            state  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (slot_free) begin
            bus_valid <= 1'b1;
            bus_data  <= next_word;
            if (phase == end_phase) begin
              state <= cnt_zero ? ST_DRAIN : ST_GET_A;
            end else if (run_fmt == FMT_PAIR && phase == 2'd0) begin
              phase <= 2'd1;
              if (cnt_zero) begin
                tail <= 1'b1;
              end else begin
                state <= ST_GET_B;
              end
            end else begin
              phase <= phase + 2'd1;
            end
          end
        end
        ST_DRAIN: begin
          if (slot_free) begin
            frame_done <= 1'b1;
            busy       <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy);

  // R5
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> busy);

  // R5
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> busy);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ((bus_data >> run_lines) == '0));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(run_type) && $stable(run_mode)));

  // R1
  run_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_ok);

endmodule

// File: tb/sim_pixel_bus_packer.sv
module sim_pixel_bus_packer;

  localparam int PIX_W = 24;
  localparam int BUS_W = 16;
  localparam int CNT_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cfg_pix_type = '0;
  logic [1:0]       cfg_bus_mode = '0;
  logic [CNT_W-1:0] frame_pixels = '0;
  logic             start = 1'b0;
  logic             pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic             pix_ready;
  logic             bus_valid;
  logic [BUS_W-1:0] bus_data;
  logic             bus_ready = 1'b0;
  logic             busy;
  logic             frame_done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  pixel_bus_packer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .cfg_pix_type (cfg_pix_type),
    .cfg_bus_mode (cfg_bus_mode),
    .frame_pixels (frame_pixels),
    .start        (start),
    .pix_valid    (pix_valid),
    .pix_data     (pix_data),
    .pix_ready    (pix_ready),
    .bus_valid    (bus_valid),
    .bus_data     (bus_data),
    .bus_ready    (bus_ready),
    .busy         (busy),
    .frame_done   (frame_done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input int pt, input int bm, input int n, input int pat);
    int P, L, kind, nc, ne, pi, wi, t, done_cyc, last_cyc, dones;
    longint lmask, pmask;
    longint px[8];
    longint ew[32];
    string wreq;
    P = (pt == 0) ? 12 : (pt == 1) ? 16 : (pt == 2) ? 18 : 24;
    L = (bm == 0) ? 8 : (bm == 1) ? 9 : (bm == 2) ? 12 : 16;
    kind = 0; nc = 0;
    if (P % L == 0 && P / L >= 1 && P / L <= 3) begin kind = 1; nc = P / L; end
    else if ((2 * P) % L == 0 && (2 * P) / L == 3) kind = 2;
    lmask = (64'd1 << L) - 1;
    pmask = (64'd1 << P) - 1;
    for (int i = 0; i < 8; i++)
      px[i] = (longint'(i + 1) * 64'h3A5C71 + longint'(pt * 4 + bm) * 64'h51D3
               + longint'(pat) * 64'h0F0F1) & 64'hFFFFFF;
    ne = 0;
    if (kind == 1) begin
      for (int i = 0; i < n; i++)
        for (int k = 0; k < nc; k++) begin
          ew[ne] = ((px[i] & pmask) >> (P - L * (k + 1))) & lmask;
          ne++;
        end
    end else if (kind == 2) begin
      for (int i = 0; i < n; i += 2) begin
        longint a, b, v;
        int nw;
        a = px[i] & pmask;
        b = (i + 1 < n) ? (px[i + 1] & pmask) : 64'd0;
        nw = (i + 1 < n) ? 3 : 2;
        v = (a << P) | b;
        for (int k = 0; k < nw; k++) begin
          ew[ne] = (v >> (2 * P - L * (k + 1))) & lmask;
          ne++;
        end
      end
    end
    wreq = (kind == 2) ? ((n % 2 == 1) ? "R3/R4" : "R3") : "R2";

    @(negedge clk);
    cfg_pix_type = 2'(pt);
    cfg_bus_mode = 2'(bm);
    frame_pixels = CNT_W'(n);
    start = 1'b1;
    pix_valid = 1'b0;
    bus_ready = 1'b0;
    pi = 0; wi = 0; done_cyc = -1; last_cyc = -1; dones = 0;
    for (t = 1; t < 400; t++) begin
      @(negedge clk);
      start = 1'b0;
      // R9: scramble config and retrigger while a frame runs
      cfg_pix_type = ~2'(pt);
      cfg_bus_mode = ~2'(bm);
      frame_pixels = CNT_W'(7);
      if (t == 3 && kind != 0 && n >= 3) start = 1'b1;
      if (t == 1) begin
        // R1 R5 R7
        chk(busy == (kind != 0 && n > 0), "R5 busy after start", longint'(busy),
            longint'(kind != 0 && n > 0));
      end
      if (frame_done) begin
        dones++;
        done_cyc = t;
        chk(!busy, "R6 busy low at done", longint'(busy), 0);
      end
      pix_valid = (pi < n) && ((pat == 0) || (pat == 1 && t % 2 == 0) || (pat == 2 && t % 3 != 2));
      pix_data = pix_valid ? PIX_W'(px[pi]) : PIX_W'(24'hA5A5A5);
      bus_ready = (pat == 0) || (pat == 1 && t % 2 == 1) || (pat == 2 && t % 4 != 0);
      #1;
      if (pix_valid && pix_ready) pi++;
      if (bus_valid && bus_ready) begin
        if (wi < ne) chk(longint'(bus_data) == ew[wi], wreq, longint'(bus_data), ew[wi]);
        else chk(1'b0, "R2 extra word", longint'(bus_data), -1);
        wi++;
        last_cyc = t;
      end
      if (done_cyc >= 0 && t > done_cyc + 3) break;
      if (kind == 0 && t > 10) break;
    end
    start = 1'b0;
    pix_valid = 1'b0;
    // R2 R3 R4: word count
    chk(wi == ne, wreq, wi, ne);
    // R5: pixel count
    chk(pi == ((kind != 0) ? n : 0), "R5 pixels taken", pi, (kind != 0) ? n : 0);
    // R1 R6 R7: done count
    chk(dones == ((kind != 0) ? 1 : 0), (kind == 0) ? "R1 unsupported" : "R6 done count",
        dones, (kind != 0) ? 1 : 0);
    if (kind != 0 && n > 0) chk(done_cyc == last_cyc + 1, "R6 done timing", done_cyc, last_cyc + 1);
    if (kind != 0 && n == 0) chk(done_cyc == 1 && wi == 0, "R7 zero count", done_cyc, 1);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !bus_valid && !frame_done && !pix_ready, "R5 reset state",
        longint'({busy, bus_valid, frame_done, pix_ready}), 0);
    for (int pat = 0; pat < 3; pat++)
      for (int pt = 0; pt < 4; pt++)
        for (int bm = 0; bm < 4; bm++) begin
          run_frame(pt, bm, 0, pat);
          run_frame(pt, bm, 1, pat);
          run_frame(pt, bm, 2, pat);
          run_frame(pt, bm, 3, pat);
          run_frame(pt, bm, 5, pat);
        end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule